// File: doc/BRIEF.md
# Keyed Watchdog Timer with Tap-Selected Prescaler

This block watches for a stalled program. A free-running prescaler counter feeds one of four taps into an 8-bit basic-timer counter. Each wrap of the basic timer advances a 3-bit watchdog counter. When that counter wraps past its top value, the block raises a one-cycle system reset request. Software keeps the system alive by writing the clear flag before the eighth basic-timer wrap.

Software reaches the block through a three-register write port: a keyed mode byte, a tap select code and a clear flag. Only one mode value, 5Ah, turns the watchdog off. The block comes out of reset with the watchdog enabled and the slowest tap selected. The basic timer is never cleared by software, so a clear or an enable lands part of the way through a basic-timer period. The timeout after either one is therefore more than seven and at most eight basic-timer periods.

Top module: `wdt_core`

## Requirements
- R1: After reset, `rst_req` is low, the watchdog is enabled, and the select code is 000 (the slowest tap). With no further writes, a reset request follows within the slowest-tap timeout window.
- R2: A write of exactly 5Ah to address 0 disables the watchdog. While the watchdog is disabled, its counter holds at zero and `rst_req` stays low.
- R3: A write of any other byte to address 0 enables the watchdog, and counting starts again from zero.
- R4: Address 1 takes a select code from `wr_data[2:0]`; bits 7:3 are ignored. The codes map to these tap exponents: 000 gives TAP0, 011 gives TAP1, 101 gives TAP2, 111 gives TAP3. Every other code uses TAP0.
- R5: The basic timer wraps once every 2^(tap+BT_W) clocks. `rst_req` rises on the eighth wrap after a clear. Measured in clocks from the clear (or enable) write edge, the delay is greater than 7·2^(tap+BT_W) and at most 8·2^(tap+BT_W)+3.
- R6: A write to address 2 with `wr_data[3]`=1 zeroes the watchdog counter. Clears repeated within seven periods prevent any reset request.
- R7: While `cpu_stop` or `cpu_wait` is high, the watchdog counter is held at zero and no reset request is raised.
- R8: `rst_req` is a registered pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 = mode key, 1 = tap select, 2 = clear flag |
| wr_data | input | 8 | Write data |
| cpu_stop | input | 1 | Stop state; holds the watchdog counter at zero |
| cpu_wait | input | 1 | Wait state; holds the watchdog counter at zero |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that `rst` is synchronous and that writes are single-cycle strobes with stable data. They assume `cpu_stop` and `cpu_wait` change only between edges. They also assume that the prescaler tap changes only together with a following clear, so that a window is never measured across a tap change. The stimulus keeps to these assumptions by driving every input on the falling edge. Each select write is followed by a clear before any timeout is measured. Random key bytes and random fallback select codes are drawn from a fixed seed, and 5Ah is excluded wherever an enabling key is intended.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ADR_MODE  = 2'd0,
    ADR_SEL   = 2'd1,
    ADR_CLEAR = 2'd2
  } wdt_addr_e;

  localparam logic [7:0] KEY_OFF    = 8'h5A;
  localparam logic [7:0] MODE_RESET = 8'hA5;
  localparam int         CLR_BIT    = 3;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TAP0 = 12,
  parameter int TAP1 = 9,
  parameter int TAP2 = 7,
  parameter int TAP3 = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int PRE_W = TAP0;
  localparam int SH_W  = $clog2(PRE_W + 1);
  localparam logic [SH_W-1:0] SH0 = SH_W'(TAP0);
  localparam logic [SH_W-1:0] SH1 = SH_W'(TAP1);
  localparam logic [SH_W-1:0] SH2 = SH_W'(TAP2);
  localparam logic [SH_W-1:0] SH3 = SH_W'(TAP3);

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] mask;
  logic [SH_W-1:0]  sh;

  always_comb begin
    unique case (sel)
      3'b011:  sh = SH1;
      3'b101:  sh = SH2;
      3'b111:  sh = SH3;
      default: sh = SH0;
    endcase
    span = {{PRE_W{1'b0}}, 1'b1} << sh;
    mask = span[PRE_W-1:0] - {{(PRE_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
      tick    <= ((pre_cnt & mask) == mask);
    end
  end
endmodule

// File: rtl/wdt_basic_timer.sv
module wdt_basic_timer #(
  parameter int BT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic ovf
);
  logic [BT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= tick && (&cnt);
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  AST_BT_IDLE: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(cnt)); // R5
  AST_BT_WRAP: assert property (@(posedge clk) disable iff (rst) ovf |-> cnt == '0); // R5
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int WD_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  input  logic hold,
  input  logic bt_ovf,
  output logic req
);
  logic [WD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      req <= 1'b0;
    end else begin
      req <= 1'b0;
      if (!en || clr || hold) begin
        cnt <= '0;
      end else if (bt_ovf) begin
        if (&cnt) begin
          cnt <= '0;
          req <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst) req |=> !req); // R8
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst) (hold || clr) |=> cnt == '0); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst) !en |=> (!req && cnt == '0)); // R2
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
                   req |-> ($past(bt_ovf) && $past(cnt) == {WD_W{1'b1}})); // R5
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int TAP0 = 12,
  parameter int TAP1 = 9,
  parameter int TAP2 = 7,
  parameter int TAP3 = 5,
  parameter int BT_W = 8,
  parameter int WD_W = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       cpu_stop,
  input  logic       cpu_wait,
  output logic       rst_req
);
  import wdt_pkg::*;

  logic [7:0] mode_q;
  logic [2:0] sel_q;
  logic       wd_en;
  logic       clr_hit;
  logic       tick;
  logic       bt_ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RESET;
      sel_q  <= 3'b000;
    end else if (wr_en) begin
      if (wr_addr == ADR_MODE) mode_q <= wr_data;
      if (wr_addr == ADR_SEL)  sel_q  <= wr_data[2:0];
    end
  end

  assign wd_en   = (mode_q != KEY_OFF);
  assign clr_hit = wr_en && (wr_addr == ADR_CLEAR) && wr_data[CLR_BIT];

  wdt_prescaler #(.TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)) u_pre (
    .clk(clk), .rst(rst), .sel(sel_q), .tick(tick)
  );

  wdt_basic_timer #(.BT_W(BT_W)) u_bt (
    .clk(clk), .rst(rst), .tick(tick), .ovf(bt_ovf)
  );

  wdt_counter #(.WD_W(WD_W)) u_wd (
    .clk(clk), .rst(rst), .en(wd_en), .clr(clr_hit),
    .hold(cpu_stop || cpu_wait), .bt_ovf(bt_ovf), .req(rst_req)
  );

  AST_KEY_OFF: assert property (@(posedge clk) disable iff (rst)
                 (wr_en && wr_addr == ADR_MODE && wr_data == KEY_OFF) |=> !wd_en); // R2
  AST_KEY_ON:  assert property (@(posedge clk) disable iff (rst)
                 (wr_en && wr_addr == ADR_MODE && wr_data != KEY_OFF) |=> wd_en); // R3
endmodule

// File: tb/tb_wdt_core.sv
module tb_wdt_core;
  localparam int T0 = 6, T1 = 4, T2 = 3, T3 = 2, BT = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       cpu_stop = 1'b0;
  logic       cpu_wait = 1'b0;
  logic       rst_req;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wdt_core #(.TAP0(T0), .TAP1(T1), .TAP2(T2), .TAP3(T3), .BT_W(BT), .WD_W(3)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_stop(cpu_stop), .cpu_wait(cpu_wait), .rst_req(rst_req)
  );

  function automatic int period(input logic [2:0] code);
    case (code)
      3'b011:  return 1 << (T1 + BT);
      3'b101:  return 1 << (T2 + BT);
      3'b111:  return 1 << (T3 + BT);
      default: return 1 << (T0 + BT);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Counts clocks until rst_req; checks the window and the pulse width.
  task automatic window(input string req, input int p);
    int n = 0;
    int lo = 7 * p;
    int hi = 8 * p + 3;
    while (!rst_req && n <= hi) begin
      @(negedge clk);
      n++;
    end
    check(rst_req && n > lo && n <= hi, req, n, hi);
    @(negedge clk);
    check(!rst_req, "R8", int'(rst_req), 0);
  endtask

  task automatic quiet(input string req, input int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rst_req) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] key;
    logic [2:0] code;
    int pf;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!rst_req, "R1", int'(rst_req), 0);
    window("R1", period(3'b000));

    // R2: key disables
    wr(2'd0, 8'h5A);
    quiet("R2", 9 * period(3'b000));

    // R3: random enabling keys, fast tap
    wr(2'd1, 8'h07);
    for (int k = 0; k < 3; k++) begin
      do key = 8'($urandom); while (key == 8'h5A);
      wr(2'd0, 8'h5A);
      quiet("R2", 2 * period(3'b111));
      wr(2'd0, key);
      window("R3", period(3'b111));
    end

    // R4/R5: each listed tap
    foreach (pf_codes[i]) begin
      wr(2'd1, {5'b0, pf_codes[i]});
      wr(2'd2, 8'h08);
      window("R5", period(pf_codes[i]));
    end

    // R4: upper bits ignored
    wr(2'd1, 8'hFB);
    wr(2'd2, 8'h08);
    window("R4", period(3'b011));

    // R4: fallback codes
    for (int k = 0; k < 2; k++) begin
      code = 3'($urandom);
      while (code == 3'b000 || code == 3'b011 || code == 3'b101 || code == 3'b111)
        code = 3'($urandom);
      wr(2'd1, {5'b0, code});
      wr(2'd2, 8'h08);
      window("R4", period(3'b000));
    end

    // R6: kicking prevents reset
    wr(2'd1, 8'h07);
    pf = period(3'b111);
    wr(2'd2, 8'h08);
    for (int k = 0; k < 5; k++) begin
      quiet("R6", 5 * pf);
      wr(2'd2, 8'h08);
    end
    window("R6", pf);

    // R7: stop and wait hold the counter
    @(negedge clk); cpu_stop = 1'b1;
    quiet("R7", 10 * pf);
    cpu_stop = 1'b0;
    window("R7", pf);
    wr(2'd2, 8'h08);
    for (int k = 0; k < 4; k++) begin
      quiet("R7", 5 * pf);
      @(negedge clk); cpu_wait = 1'b1;
      @(negedge clk); cpu_wait = 1'b0;
    end
    check(!rst_req, "R7", int'(rst_req), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  logic [2:0] pf_codes [4] = '{3'b000, 3'b011, 3'b101, 3'b111};
endmodule